// File: doc/BRIEF.md
# Fully Associative Cache with Aging Replacement

This block is a small fully associative cache of data words. Every stored word carries its full address as a tag, so a word may sit in any slot. A lookup compares the request address against every occupied slot at once and reports the hit, the slot number and the stored word in the same cycle. Writes follow a write-through, no-allocate policy. A write that hits updates the stored copy, and the caller forwards every write to memory. A write that misses leaves the cache untouched.

Refills arrive on a separate fill port from the agent that fetched the missing word. The fill port takes priority. While `fill_valid` is high, `req_ready` is low and the request is not accepted. A request is accepted only in a cycle with `req_valid && req_ready`. The requester holds its request until it is accepted. The fill port has no ready and is accepted in the cycle it is presented.

Replacement is an approximation of least-recently-used order. Each slot has a "used" flag and an "aged" flag. Every accepted hit sets the used flag of that slot. A free-running timer raises `age_pulse` for one cycle every `AGE_PERIOD` cycles. At that edge, each occupied slot whose used flag is clear becomes aged, and all used flags are cleared. The block always shows the slot the next fill will replace on `victim_idx`.

Top module: `assoc_age_cache`

## Requirements
- R1: After reset no slot is occupied, `victim_idx` is 0, `age_pulse` is 0 and `req_ready` is 1.
- R2: While `req_valid` is high, `rsp_hit`, `rsp_idx` and `rsp_data` reflect a match of `req_addr` against all occupied slots in the same cycle. On a hit, `rsp_data` is the word stored before any write in that cycle. At most one slot ever matches.
- R3: Unoccupied slots never match, whatever their stale contents.
- R4: While any slot is unoccupied, `victim_idx` is the lowest-numbered unoccupied slot, and a fill of a new address lands there.
- R5: An accepted write that hits replaces the stored word. A write that misses creates no entry, so a later read of that address still misses.
- R6: A fill whose address is already held overwrites that slot in place, so no duplicate is created.
- R7: `req_ready` is low in every cycle where `fill_valid` is high. A request presented in such a cycle has no effect.
- R8: `age_pulse` is high for one cycle every `AGE_PERIOD` cycles. At the edge ending that cycle, occupied slots with a clear used flag become aged and all used flags clear.
- R9: With all slots occupied and at least one aged, `victim_idx` is the lowest-numbered aged slot.
- R10: With all slots occupied and none aged, `victim_idx` is the lowest-numbered slot whose used flag is clear. If every used flag is set, it is 0.
- R11: A filled slot, and a slot hit by an accepted request, end that cycle with the used flag set and the aged flag clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted this cycle (low during a fill) |
| req_write | input | 1 | 1 = write request, 0 = read |
| req_addr | input | ADDR_W | Word address to look up |
| req_wdata | input | DATA_W | Write data |
| rsp_hit | output | 1 | Request address matches an occupied slot |
| rsp_idx | output | IDX_W | Matching slot number |
| rsp_data | output | DATA_W | Word held in the matching slot |
| fill_valid | input | 1 | Refill word present |
| fill_addr | input | ADDR_W | Refill address |
| fill_data | input | DATA_W | Refill word |
| victim_idx | output | IDX_W | Slot the next fill of a new address will use |
| age_pulse | output | 1 | Aging pass takes effect at the end of this cycle |

## Verification
The hardest condition to reach from the ports is a full cache with a known mix of aged and used slots. Aging depends on the free-running timer and on every hit since the previous pass. The stimulus first fills every slot. It then waits for one `age_pulse` so that all used flags are cleared. Next it reads every slot except two chosen ones and waits for the following pulse. Only those two slots are then aged. Fills and hits made before the next pulse walk `victim_idx` through the aged, least-used and all-used cases.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;

  // Lowest set bit among the first n bits of v; 0 when none is set.
  function automatic int lowest_set(input logic [63:0] v, input int n);
    int r;
    r = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/assoc_cam_match.sv
module assoc_cam_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ENTRIES-1:0]             slot_live,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  slot_tag,
  input  logic [TAG_W-1:0]               key,
  output logic [ENTRIES-1:0]             match_vec,
  output logic                           any_match,
  output logic [IDX_W-1:0]               match_idx
);

  // Parallel compare, gated by the occupied flag.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = slot_live[e] && (slot_tag[e] == key);
  end

  assign any_match = |match_vec;

  // One-hot to binary: each index bit ORs the lines whose number has it set.
  for (genvar b = 0; b < IDX_W; b++) begin : g_enc
    logic [ENTRIES-1:0] sel;
    for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
      assign sel[e] = match_vec[e] && ((e >> b) & 1) == 1;
    end
    assign match_idx[b] = |sel;
  end

  assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

endmodule

// File: rtl/assoc_age_ctrl.sv
module assoc_age_ctrl #(
  parameter int ENTRIES    = 8,
  parameter int AGE_PERIOD = 64,
  parameter int IDX_W      = $clog2(ENTRIES),
  localparam int CNT_W     = (AGE_PERIOD > 1) ? $clog2(AGE_PERIOD) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] slot_live,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  output logic [ENTRIES-1:0] used,
  output logic [ENTRIES-1:0] aged,
  output logic               tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(AGE_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // Later assignments win per bit: aging first, then hit, then fill.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
      aged <= '0;
    end else begin
      if (tick) begin
        aged <= slot_live & ~used;
        used <= '0;
      end
      if (touch_en) begin
        used[touch_idx] <= 1'b1;
        aged[touch_idx] <= 1'b0;
      end
      if (fill_en) begin
        used[fill_idx] <= 1'b1;
        aged[fill_idx] <= 1'b0;
      end
    end
  end

  assert_fill_marks_used_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (used[$past(fill_idx)] && !aged[$past(fill_idx)]));

  assert_age_clears_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !touch_en && !fill_en) |=> (used == '0));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (AGE_PERIOD > 1 && tick) |=> !tick);

endmodule

// File: rtl/assoc_victim_pick.sv
module assoc_victim_pick
  import assoc_cache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] slot_live,
  input  logic [ENTRIES-1:0] used,
  input  logic [ENTRIES-1:0] aged,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [63:0] free_w, aged_w, cold_w;

  always_comb begin
    free_w = '0;
    aged_w = '0;
    cold_w = '0;
    free_w[ENTRIES-1:0] = ~slot_live;
    aged_w[ENTRIES-1:0] = aged & slot_live;
    cold_w[ENTRIES-1:0] = ~used;
    if (!(&slot_live))      victim_idx = IDX_W'(lowest_set(free_w, ENTRIES));
    else if (|aged_w)       victim_idx = IDX_W'(lowest_set(aged_w, ENTRIES));
    else if (!(&used))      victim_idx = IDX_W'(lowest_set(cold_w, ENTRIES));
    else                    victim_idx = '0;
  end

  assert_free_slot_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(&slot_live) |-> !slot_live[victim_idx]);

  assert_aged_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&slot_live) && |aged) |-> aged[victim_idx]);

endmodule

// File: rtl/assoc_age_cache.sv
module assoc_age_cache #(
  parameter int ENTRIES    = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int AGE_PERIOD = 64,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic [IDX_W-1:0]  victim_idx,
  output logic              age_pulse
);

  logic [ENTRIES-1:0]             live_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [ENTRIES-1:0]             used, aged;

  logic [ENTRIES-1:0] req_match_vec, fill_match_vec;
  logic               req_match, fill_match;
  logic [IDX_W-1:0]   req_match_idx, fill_match_idx, fill_slot;
  logic               fire, hit_fire;

  assoc_cam_match #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W), .IDX_W(IDX_W)) u_req_cam (
    .clk(clk), .rst_n(rst_n), .slot_live(live_q), .slot_tag(tag_q), .key(req_addr),
    .match_vec(req_match_vec), .any_match(req_match), .match_idx(req_match_idx));

  assoc_cam_match #(.ENTRIES(ENTRIES), .TAG_W(ADDR_W), .IDX_W(IDX_W)) u_fill_cam (
    .clk(clk), .rst_n(rst_n), .slot_live(live_q), .slot_tag(tag_q), .key(fill_addr),
    .match_vec(fill_match_vec), .any_match(fill_match), .match_idx(fill_match_idx));

  assoc_victim_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .slot_live(live_q), .used(used), .aged(aged),
    .victim_idx(victim_idx));

  assign req_ready = !fill_valid;
  assign fire      = req_valid && req_ready;
  assign hit_fire  = fire && req_match;
  assign fill_slot = fill_match ? fill_match_idx : victim_idx;

  assoc_age_ctrl #(.ENTRIES(ENTRIES), .AGE_PERIOD(AGE_PERIOD), .IDX_W(IDX_W)) u_age (
    .clk(clk), .rst_n(rst_n), .slot_live(live_q),
    .touch_en(hit_fire), .touch_idx(req_match_idx),
    .fill_en(fill_valid), .fill_idx(fill_slot),
    .used(used), .aged(aged), .tick(age_pulse));

  assign rsp_hit  = req_valid && req_match;
  assign rsp_idx  = req_match_idx;
  assign rsp_data = data_q[req_match_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      tag_q  <= '0;
      data_q <= '0;
    end else if (fill_valid) begin
      live_q[fill_slot] <= 1'b1;
      tag_q[fill_slot]  <= fill_addr;
      data_q[fill_slot] <= fill_data;
    end else if (hit_fire && req_write) begin
      data_q[req_match_idx] <= req_wdata;
    end
  end

  assert_fill_blocks_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !req_ready);

  assert_write_miss_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && !req_match) |=> (live_q == $past(live_q)));

  assert_hit_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_fire && req_write) |=> (data_q[$past(req_match_idx)] == $past(req_wdata)));

endmodule

// File: tb/assoc_age_cache_test.sv
module assoc_age_cache_test;

  localparam int PERIOD  = 10;
  localparam int ENTRIES = 8;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int AGE_P   = 64;
  localparam int NVEC    = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, rsp_hit, age_pulse;
  logic [2:0]        rsp_idx, victim_idx;
  logic [DATA_W-1:0] rsp_data;
  logic              fill_valid = 1'b0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [DATA_W-1:0] fill_data = '0;

  int checks = 0, fails = 0;
  logic              s_hit, s_ready;
  logic [2:0]        s_idx;
  logic [DATA_W-1:0] s_data;

  assoc_age_cache #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGE_PERIOD(AGE_P)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .victim_idx(victim_idx), .age_pulse(age_pulse));

  always #(PERIOD/2) clk = ~clk;

  // {write, addr, wdata, exp_hit, exp_idx, exp_data}
  localparam logic [84:0] VEC [NVEC] = '{
    {1'b0, 16'h0100, 32'h0, 1'b1, 3'd0, 32'hA000},
    {1'b0, 16'h0107, 32'h0, 1'b1, 3'd7, 32'hA007},
    {1'b0, 16'h0104, 32'h0, 1'b1, 3'd4, 32'hA004},
    {1'b0, 16'h0000, 32'h0, 1'b0, 3'd0, 32'h0},
    {1'b0, 16'h0108, 32'h0, 1'b0, 3'd0, 32'h0},
    {1'b1, 16'h0103, 32'hBEEF, 1'b1, 3'd3, 32'hA003},
    {1'b0, 16'h0103, 32'h0, 1'b1, 3'd3, 32'hBEEF},
    {1'b1, 16'h0200, 32'h5555, 1'b0, 3'd0, 32'h0},
    {1'b0, 16'h0200, 32'h0, 1'b0, 3'd0, 32'h0},
    {1'b0, 16'h0106, 32'h0, 1'b1, 3'd6, 32'hA006},
    {1'b0, 16'h0101, 32'h0, 1'b1, 3'd1, 32'hA001},
    {1'b0, 16'h01FF, 32'h0, 1'b0, 3'd0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present a request for one cycle, capturing the same-cycle response.
  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    s_hit = rsp_hit; s_idx = rsp_idx; s_data = rsp_data; s_ready = req_ready;
    @(posedge clk);
    #1 req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_data = d;
    @(posedge clk);
    #1 fill_valid = 1'b0;
  endtask

  task automatic wait_pulse(output time t);
    @(negedge clk);
    while (!age_pulse) @(negedge clk);
    t = $time;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    time ta, tb;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R3: empty after reset; stale zero contents must not match addr 0.
    @(negedge clk);
    check("R1 victim", victim_idx, 0);
    check("R1 ready", req_ready, 1);
    check("R1 pulse", age_pulse, 0);
    access(1'b0, 16'h0000, 32'h0);
    check("R3 empty miss", s_hit, 0);

    // R4: fills take the lowest free slot.
    for (int i = 0; i < ENTRIES; i++) begin
      @(negedge clk);
      check("R4 free slot", victim_idx, i);
      fill(16'h0100 + ADDR_W'(i), 32'hA000 + i);
    end

    // R2 / R3 / R5: vector table of lookups.
    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][84], VEC[v][83:68], VEC[v][67:36]);
      check("R2 hit", s_hit, VEC[v][35]);
      if (VEC[v][35]) begin
        check("R2 idx", s_idx, VEC[v][34:32]);
        check(VEC[v][84] ? "R5 data" : "R2 data", s_data, VEC[v][31:0]);
      end else if (v == 8) begin
        check("R5 write miss no alloc", s_hit, 0);
      end
    end

    // R7 / R6: fill and request together; fill of held address overwrites slot 1.
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = 16'h0101; fill_data = 32'hC101;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0104; req_wdata = 32'hDEAD;
    #1 check("R7 ready low", req_ready, 0);
    @(posedge clk);
    #1 fill_valid = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    access(1'b0, 16'h0104, 32'h0);
    check("R7 blocked write no effect", s_data, 32'hA004);
    access(1'b0, 16'h0101, 32'h0);
    check("R6 overwrite idx", s_idx, 1);
    check("R6 overwrite data", s_data, 32'hC101);

    // R8-R11: controlled aging with slots 2 and 5 left unused.
    wait_pulse(ta);
    for (int i = 0; i < ENTRIES; i++)
      if (i != 2 && i != 5) access(1'b0, 16'h0100 + ADDR_W'(i), 32'h0);
    wait_pulse(tb);
    check("R8 period", 32'((tb - ta) / PERIOD), AGE_P);
    @(negedge clk);
    check("R9 aged victim", victim_idx, 2);
    fill(16'h0300, 32'hD300);
    access(1'b0, 16'h0300, 32'h0);
    check("R9 fill landed", s_idx, 2);
    @(negedge clk);
    check("R11 fresh fill not aged", victim_idx, 5);
    access(1'b0, 16'h0105, 32'h0);
    @(negedge clk);
    check("R11 hit clears aged / R10 lowest unused", victim_idx, 0);
    access(1'b0, 16'h0100, 32'h0);
    access(1'b0, 16'h0101, 32'h0);
    @(negedge clk);
    check("R10 lowest unused", victim_idx, 3);
    access(1'b0, 16'h0103, 32'h0);
    access(1'b0, 16'h0104, 32'h0);
    access(1'b0, 16'h0106, 32'h0);
    access(1'b0, 16'h0107, 32'h0);
    @(negedge clk);
    check("R10 all used", victim_idx, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule